// File: doc/BRIEF.md
# CAN Error Frame Sequencer

This block produces and follows the error frame of a CAN node once the node's error detector reports a bus error. It works on bit time: a single-cycle strobe marks the instant at which the bus level has been sampled. The error-passive status is captured at the moment an error is reported. A node in the error-active state pulls the bus dominant for its flag. A node in the error-passive state keeps the bus recessive for the same number of bits.

After its own flag, an error-active node releases the bus. It then absorbs the dominant echo flags that other nodes may add, and starts the delimiter count on the first recessive bit. An error-passive node counts its delimiter straight after its recessive flag. It must then see a further stretch of recessive bus before it rejoins. When the frame is complete, the block pulses a completion signal and asks for the aborted message to be sent again. The block also flags a dominant stretch on the bus that is longer than any legal flag plus echo.

Top module: `can_errframe_seq`

## Requirements
- R1: After reset, and whenever the block is idle, `tx_bit` is 1 (recessive), `busy`, `done`, `resend_req` and `dom_overrun` are 0. Bit strobes with any bus level leave it idle.
- R2: An `err_det` high at a rising clock edge while idle makes `busy` high from the next cycle. An `err_det` while busy is ignored and does not change the frame's timing.
- R3: In error-active mode, `tx_bit` is 0 (dominant) from acceptance until the 6th bit strobe of the flag, and 1 after it.
- R4: In error-passive mode, `tx_bit` stays 1 for the whole frame. The six flag strobes are followed directly by delimiter counting.
- R5: In error-active mode, after the six flag strobes the block waits for the first strobe with `rx_bit`=1. That strobe counts as delimiter bit one, however many dominant echo bits came before it.
- R6: The delimiter needs eight consecutive strobes with `rx_bit`=1. A strobe with `rx_bit`=0 during the delimiter sets the count back to zero.
- R7: In error-passive mode, after the delimiter the block needs six more consecutive recessive strobes before it completes. A dominant strobe sets this count back to zero.
- R8: On completion, `done` and `resend_req` are high for exactly one cycle, in the cycle after the completing strobe, and `busy` is low in that same cycle.
- R9: While busy, `dom_overrun` pulses for one cycle after the 13th consecutive strobe with `rx_bit`=0. It pulses only once per dominant run.
- R10: `err_passive` is sampled only when an error is accepted. Later changes to it within the frame have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | Single-cycle strobe once per bit time, marking the sample point |
| rx_bit | input | 1 | Sampled bus level, 1 = recessive, 0 = dominant |
| err_det | input | 1 | Bus error reported by the detector |
| err_passive | input | 1 | 1 = node is error-passive |
| tx_bit | output | 1 | Bit to transmit, 1 = recessive, 0 = dominant |
| busy | output | 1 | Error frame in progress |
| done | output | 1 | One-cycle pulse when the frame completes |
| resend_req | output | 1 | One-cycle request to resend the aborted message |
| dom_overrun | output | 1 | One-cycle pulse on a dominant run longer than twelve bits |

## Verification
The hardest case to reach is a dominant bit that arrives in the middle of a delimiter or rejoin count after an echo of varying length. The count must restart there, and only the exact strobe that completes it may raise `done`. Random bus patterns give error-active frames an echo length of zero to eight bits, followed by recessive bits with sparse dominant glitches. Error-passive frames get denser random dominant bits. A bench model steps through each pattern strobe by strobe to predict the completion and overrun strobes. Directed frames pin down the run-length edge at twelve and thirteen dominant bits, and an error report with a flipped mode input is injected in the middle of every frame.

// File: rtl/ef_pkg.sv
package ef_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FLAG,
        ST_WAIT_REC,
        ST_DELIM,
        ST_REJOIN
    } ef_state_e;

    function automatic int ef_max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/ef_dom_monitor.sv
module ef_dom_monitor #(
    parameter int MAX_DOM = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic bit_tick,
    input  logic rx_bit,
    output logic overrun
);
    localparam int RW = $clog2(MAX_DOM + 2);
    localparam logic [RW-1:0] RUN_LIM = RW'(MAX_DOM);

    typedef struct packed {
        logic [RW-1:0] run;
        logic          ovr;
    } mon_t;

    mon_t mon_d, mon_q;

    always_comb begin
        mon_d     = mon_q;
        mon_d.ovr = 1'b0;
        if (!armed) begin
            mon_d.run = '0;
        end else if (bit_tick) begin
            if (rx_bit) begin
                mon_d.run = '0;
            end else begin
                if (mon_q.run == RUN_LIM) begin
                    mon_d.ovr = 1'b1;
                end
                if (mon_q.run <= RUN_LIM) begin
                    mon_d.run = mon_q.run + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mon_q <= '0;
        end else begin
            mon_q <= mon_d;
        end
    end

    assign overrun = mon_q.ovr;

    AST_OVR_NEEDS_DOM: assert property (@(posedge clk) disable iff (!rst_n)
        mon_q.ovr |-> $past(armed && bit_tick && !rx_bit)); // R9
    AST_OVR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mon_q.ovr |=> !mon_q.ovr); // R9

endmodule

// File: rtl/ef_frame_fsm.sv
module ef_frame_fsm
    import ef_pkg::*;
#(
    parameter int FLAG_BITS   = 6,
    parameter int DELIM_BITS  = 8,
    parameter int REJOIN_BITS = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic rx_bit,
    input  logic err_det,
    input  logic err_passive,
    output logic tx_bit,
    output logic busy,
    output logic done
);
    localparam int MAXC = ef_max3(FLAG_BITS, DELIM_BITS, REJOIN_BITS);
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] FLAG_LAST   = CW'(FLAG_BITS - 1);
    localparam logic [CW-1:0] DELIM_LAST  = CW'(DELIM_BITS - 1);
    localparam logic [CW-1:0] REJOIN_LAST = CW'(REJOIN_BITS - 1);

    typedef struct packed {
        ef_state_e     state;
        logic [CW-1:0] cnt;
        logic          passive;
        logic          tx;
        logic          done;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d      = fsm_q;
        fsm_d.done = 1'b0;
        unique case (fsm_q.state)
            ST_IDLE: begin
                fsm_d.tx = 1'b1;
                if (err_det) begin
                    fsm_d.state   = ST_FLAG;
                    fsm_d.cnt     = '0;
                    fsm_d.passive = err_passive;
                    fsm_d.tx      = err_passive;
                end
            end
            ST_FLAG: begin
                if (bit_tick) begin
                    if (fsm_q.cnt == FLAG_LAST) begin
                        fsm_d.cnt   = '0;
                        fsm_d.tx    = 1'b1;
                        fsm_d.state = fsm_q.passive ? ST_DELIM : ST_WAIT_REC;
                    end else begin
                        fsm_d.cnt = fsm_q.cnt + 1'b1;
                    end
                end
            end
            ST_WAIT_REC: begin
                if (bit_tick && rx_bit) begin
                    fsm_d.cnt   = CW'(1);
                    fsm_d.state = ST_DELIM;
                end
            end
            ST_DELIM: begin
                if (bit_tick) begin
                    if (!rx_bit) begin
                        fsm_d.cnt = '0;
                    end else if (fsm_q.cnt == DELIM_LAST) begin
                        fsm_d.cnt = '0;
                        if (fsm_q.passive) begin
                            fsm_d.state = ST_REJOIN;
                        end else begin
                            fsm_d.state = ST_IDLE;
                            fsm_d.done  = 1'b1;
                        end
                    end else begin
                        fsm_d.cnt = fsm_q.cnt + 1'b1;
                    end
                end
            end
            ST_REJOIN: begin
                if (bit_tick) begin
                    if (!rx_bit) begin
                        fsm_d.cnt = '0;
                    end else if (fsm_q.cnt == REJOIN_LAST) begin
                        fsm_d.cnt   = '0;
                        fsm_d.state = ST_IDLE;
                        fsm_d.done  = 1'b1;
                    end else begin
                        fsm_d.cnt = fsm_q.cnt + 1'b1;
                    end
                end
            end
            default: begin
                fsm_d = '{state: ST_IDLE, cnt: '0, passive: 1'b0, tx: 1'b1, done: 1'b0};
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q <= '{state: ST_IDLE, cnt: '0, passive: 1'b0, tx: 1'b1, done: 1'b0};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign tx_bit = fsm_q.tx;
    assign busy   = (fsm_q.state != ST_IDLE);
    assign done   = fsm_q.done;

    AST_IDLE_RECESSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.state == ST_IDLE) |-> fsm_q.tx); // R1
    AST_ACTIVE_FLAG_DOM: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.state == ST_FLAG && !fsm_q.passive) |-> !fsm_q.tx); // R3
    AST_PASSIVE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.passive && fsm_q.state != ST_IDLE) |-> fsm_q.tx); // R4
    AST_WAIT_ACTIVE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.state == ST_WAIT_REC) |-> !fsm_q.passive); // R5
    AST_REJOIN_PASSIVE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.state == ST_REJOIN) |-> fsm_q.passive); // R7
    AST_DONE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_q.done |-> (fsm_q.state == ST_IDLE && $past(bit_tick && rx_bit))); // R8
    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.state != ST_IDLE && $past(fsm_q.state) != ST_IDLE) |-> $stable(fsm_q.passive)); // R10

endmodule

// File: rtl/can_errframe_seq.sv
module can_errframe_seq #(
    parameter int FLAG_BITS   = 6,
    parameter int DELIM_BITS  = 8,
    parameter int REJOIN_BITS = 6,
    parameter int MAX_DOM     = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic rx_bit,
    input  logic err_det,
    input  logic err_passive,
    output logic tx_bit,
    output logic busy,
    output logic done,
    output logic resend_req,
    output logic dom_overrun
);
    logic busy_w;
    logic done_w;

    ef_frame_fsm #(
        .FLAG_BITS  (FLAG_BITS),
        .DELIM_BITS (DELIM_BITS),
        .REJOIN_BITS(REJOIN_BITS)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_tick   (bit_tick),
        .rx_bit     (rx_bit),
        .err_det    (err_det),
        .err_passive(err_passive),
        .tx_bit     (tx_bit),
        .busy       (busy_w),
        .done       (done_w)
    );

    ef_dom_monitor #(
        .MAX_DOM(MAX_DOM)
    ) u_mon (
        .clk     (clk),
        .rst_n   (rst_n),
        .armed   (busy_w),
        .bit_tick(bit_tick),
        .rx_bit  (rx_bit),
        .overrun (dom_overrun)
    );

    assign busy       = busy_w;
    assign done       = done_w;
    assign resend_req = done_w;

    AST_DONE_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy))); // R8
    AST_IDLE_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> !dom_overrun); // R1

endmodule

// File: tb/tb_can_errframe_seq.sv
module tb_can_errframe_seq;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_tick = 1'b0;
    logic rx_bit = 1'b1;
    logic err_det = 1'b0;
    logic err_passive = 1'b0;
    logic tx_bit, busy, done, resend_req, dom_overrun;

    int n_chk = 0;
    int n_fail = 0;
    logic rxp [64];

    always #10 clk = ~clk;

    can_errframe_seq dut (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .rx_bit(rx_bit),
        .err_det(err_det), .err_passive(err_passive), .tx_bit(tx_bit),
        .busy(busy), .done(done), .resend_req(resend_req), .dom_overrun(dom_overrun)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic chk_int(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    function automatic void fill_active(input int echo, input int glitch_at);
        for (int i = 0; i < 64; i++) rxp[i] = 1'b1;
        for (int i = 0; i < 6 + echo; i++) rxp[i] = 1'b0;
        if (glitch_at >= 0) rxp[glitch_at] = 1'b0;
    endfunction

    // Drives one error frame over the stored bus pattern and predicts each strobe.
    task automatic run_frame(input logic pas, output int done_t, output int ovr_t);
        int run, ph, c;
        logic exp_done, exp_ovr, exp_tx;
        run = 0; ph = 0; c = 0; done_t = -1; ovr_t = -1;
        @(negedge clk);
        err_det = 1'b1; err_passive = pas;
        @(negedge clk);
        err_det = 1'b0;
        chk("R2 busy after accept", busy, 1'b1);
        chk("R3/R4 flag level", tx_bit, pas);
        for (int t = 0; t < 64; t++) begin
            rx_bit = rxp[t]; bit_tick = 1'b1;
            if (t == 3) begin err_det = 1'b1; err_passive = ~pas; end // R2 R10 mid-frame
            @(negedge clk);
            bit_tick = 1'b0; err_det = 1'b0; err_passive = pas;
            exp_ovr = (!rxp[t] && run == 12);
            if (exp_ovr) ovr_t = t;
            run = rxp[t] ? 0 : ((run < 13) ? run + 1 : run);
            exp_done = 1'b0;
            case (ph)
                0: if (t == 5) begin ph = pas ? 2 : 1; c = 0; end
                1: if (rxp[t]) begin c = 1; ph = 2; end
                2: if (!rxp[t]) c = 0;
                   else begin
                       c++;
                       if (c == 8) begin c = 0; if (pas) ph = 3; else exp_done = 1'b1; end
                   end
                default: if (!rxp[t]) c = 0;
                   else begin c++; if (c == 6) exp_done = 1'b1; end
            endcase
            exp_tx = pas ? 1'b1 : ((ph == 0) ? 1'b0 : 1'b1);
            chk("R3/R4 tx level", tx_bit, exp_tx);
            chk("R6/R7 done", done, exp_done);
            chk("R8 resend_req", resend_req, exp_done);
            chk("R8 busy", busy, !exp_done);
            chk("R9 overrun", dom_overrun, exp_ovr);
            @(negedge clk);
            chk("R8 done single cycle", done, 1'b0);
            chk("R9 overrun single cycle", dom_overrun, 1'b0);
            if (exp_done) begin
                chk("R1 idle tx", tx_bit, 1'b1);
                chk("R1 idle busy", busy, 1'b0);
                done_t = t;
                return;
            end
            @(negedge clk);
        end
        chk_int("R6 frame completion", done_t, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int dt, ot, seed_v;
        seed_v = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset tx", tx_bit, 1'b1);
        chk("R1 reset busy", busy, 1'b0);
        chk("R1 reset done", done, 1'b0);
        chk("R1 reset resend", resend_req, 1'b0);
        chk("R1 reset overrun", dom_overrun, 1'b0);

        // R1: strobes with a dominant bus while idle do nothing
        for (int i = 0; i < 20; i++) begin
            rx_bit = 1'b0; bit_tick = 1'b1;
            @(negedge clk); bit_tick = 1'b0;
            chk("R1 idle stays idle", busy, 1'b0);
            chk("R1 idle no overrun", dom_overrun, 1'b0);
            chk("R1 idle tx", tx_bit, 1'b1);
        end
        rx_bit = 1'b1;

        // R3 R5 R6: clean active frame, no echo
        fill_active(0, -1);
        run_frame(1'b0, dt, ot);
        chk_int("R6 active clean completion strobe", dt, 13);
        chk_int("R9 no overrun clean", ot, -1);
        // R5 R9: echo to twelve dominant bits, no overrun
        fill_active(6, -1);
        run_frame(1'b0, dt, ot);
        chk_int("R5 twelve dominant completion", dt, 19);
        chk_int("R9 twelve dominant no overrun", ot, -1);
        // R9: thirteen dominant bits
        fill_active(7, -1);
        run_frame(1'b0, dt, ot);
        chk_int("R9 thirteen dominant overrun strobe", ot, 12);
        chk_int("R5 thirteen dominant completion", dt, 20);
        // R6: dominant glitch inside the delimiter restarts the count
        fill_active(2, 12);
        run_frame(1'b0, dt, ot);
        chk_int("R6 delimiter restart", dt, 20);
        // R4 R7: clean passive frame
        for (int i = 0; i < 64; i++) rxp[i] = 1'b1;
        run_frame(1'b1, dt, ot);
        chk_int("R7 passive clean completion strobe", dt, 19);
        // R7: dominant in the rejoin window
        rxp[16] = 1'b0;
        run_frame(1'b1, dt, ot);
        chk_int("R7 rejoin restart", dt, 22);

        // random frames
        for (int k = 0; k < 40; k++) begin
            logic pas;
            pas = 1'($urandom_range(0, 1));
            if (!pas) begin
                int echo;
                echo = $urandom_range(0, 8);
                fill_active(echo, -1);
                for (int i = 7 + echo; i < 40; i++) rxp[i] = ($urandom_range(0, 9) != 0);
            end else begin
                for (int i = 0; i < 64; i++)
                    rxp[i] = (i >= 40) ? 1'b1 : logic'($urandom_range(0, 4) != 0);
            end
            run_frame(pas, dt, ot);
            repeat ($urandom_range(0, 3)) @(negedge clk);
        end
        finish_run();
    end

endmodule